// File: doc/BRIEF.md
# Inverse-Time Fault Trip Timer

This block turns a stream of differential-current readings into a decision to fire the trip solenoid of a ground-fault breaker. An upstream digital filter hands it one magnitude per sample strobe, in whole milliamperes. The block compares each reading against three current bands. Each band keeps its own accumulation timer in millisecond ticks, and a larger current uses a shorter time allowance. A separate fast path counts consecutive saturation-level samples and trips without waiting for a millisecond tick.

Once any timer expires, a trip request is latched until reset. The solenoid drive output then fires for a programmable number of millisecond ticks. It is held off whenever the mains is inside its zero-crossing window, so the coil is never energized when there is too little line voltage to pull it in.

Top module: `trip_timer`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `trip_req` and `scr_fire` are 0.
- R2: Readings below the lowest band limit (default 5 mA) never start a timer, so a steady leakage of 4 mA held for 300 ticks causes no trip.
- R3: A reading of at least 5 mA and below 20 mA trips after 120 ticks of continuous presence and not after 119 ticks.
- R4: A reading of at least 20 mA and below 40 mA trips after 60 ticks and not after 59 ticks.
- R5: A reading of at least 40 mA trips after 20 ticks and not after 19 ticks.
- R6: Four consecutive samples of at least 300 mA trip without any tick. Any sample below 300 mA restarts that count.
- R7: A sample below a band's lower limit clears that band's timer, so the time spent in a band before a dip below it does not count toward a later trip.
- R8: A band timer keeps counting when the reading moves between bands that are both at or above its limit. A fault that starts at 50 mA and falls to 10 mA trips when the lowest band reaches 120 ticks in total.
- R9: Once `trip_req` is set, it stays 1 until reset, whatever the later readings are.
- R10: `scr_fire` is 1 only while `trip_req` is 1 and `zc_win` was 0 in the previous cycle. A trip raised during the zero-crossing window does not fire until the window closes.
- R11: The fire pulse lasts for 3 ticks counted only while firing. Ticks that fall inside the zero-crossing window are not counted. After the third tick, `scr_fire` stays 0 until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_vld | input | 1 | Strobe: `mag_ma` carries a new reading |
| mag_ma | input | 10 | Differential current magnitude in mA |
| zc_win | input | 1 | 1 while the mains is near a zero crossing |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| trip_req | output | 1 | Latched trip request |
| scr_fire | output | 1 | Solenoid drive pulse, blanked near zero crossings |

## Verification
The bench drives each band to one tick short of its limit and then one tick past it. An off-by-one in a band counter would show up as an early or late trip. A dip to 3 mA partway through a mid-band fault checks that timers clear; a design that only pauses them would trip too soon. A fault that moves from the high band down to the low band checks that the lowest band keeps its accumulated time; a design that restarts all timers on any band change would trip late. The fire stage is interrupted by the zero-crossing window, with ticks arriving inside the window. A gate that counts those ticks would end the pulse early, and a gate that ignores the window would fire during it.

// File: rtl/tt_pkg.sv
// Package: shared constants for the trip timer.
// Assumes: three inverse-time bands, ordered from lowest to highest current.
package tt_pkg;
    localparam int unsigned NUM_BANDS = 3;
endpackage

// File: rtl/tt_band_timer.sv
// Module: one band accumulation timer.
// Counts millisecond ticks while the latest reading is at or above LO_MA.
// A reading below LO_MA clears the count. Reports expiry once the count
// reaches LIMIT, and holds the count there.
// Assumes: sample_vld and ms_tick are single-cycle pulses.
module tt_band_timer #(
    parameter int unsigned MAG_W = 10,
    parameter int unsigned LO_MA = 5,
    parameter int unsigned LIMIT = 120
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample_vld,
    input  logic [MAG_W-1:0] mag_ma,
    input  logic             ms_tick,
    output logic             expired
);
    localparam int unsigned CW = $clog2(LIMIT + 1);

    logic          armed;
    logic [CW-1:0] cnt;
    logic          in_band;

    assign in_band = (32'(mag_ma) >= LO_MA);
    assign expired = (32'(cnt) == LIMIT);

    // Track whether the latest reading sits in or above this band.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b0;
        end else if (sample_vld) begin
            armed <= in_band;
        end
    end

    // Accumulate ticks while armed; clear on a reading below the band.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (sample_vld && !in_band) begin
            cnt <= '0;
        end else if (ms_tick && armed && !expired) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/tt_sat_detect.sv
// Module: fast saturation path.
// Counts consecutive samples at or above SAT_MA and flags a hit after
// SAT_SAMPLES of them. Any lower sample restarts the count.
// Assumes: the sample rate is high enough that SAT_SAMPLES spans well under
// the fast-trip deadline.
module tt_sat_detect #(
    parameter int unsigned MAG_W       = 10,
    parameter int unsigned SAT_MA      = 300,
    parameter int unsigned SAT_SAMPLES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample_vld,
    input  logic [MAG_W-1:0] mag_ma,
    output logic             hit
);
    localparam int unsigned CW = $clog2(SAT_SAMPLES + 1);

    logic [CW-1:0] run_cnt;

    assign hit = (32'(run_cnt) == SAT_SAMPLES);

    // Count consecutive saturation-level samples, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt <= '0;
        end else if (sample_vld) begin
            if (32'(mag_ma) < SAT_MA) begin
                run_cnt <= '0;
            end else if (!hit) begin
                run_cnt <= run_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/tt_fire_gate.sv
// Module: solenoid fire gate.
// Once trip is set, drives fire whenever the zero-crossing window is closed,
// until FIRE_TICKS ticks have passed while firing. Ticks inside the window do
// not count.
// Assumes: zc_win leads the true zero crossing by at least one clock.
module tt_fire_gate #(
    parameter int unsigned FIRE_TICKS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trip,
    input  logic zc_win,
    input  logic ms_tick,
    output logic fire
);
    localparam int unsigned CW = $clog2(FIRE_TICKS + 1);

    logic [CW-1:0] fired_cnt;
    logic [CW-1:0] fired_nxt;
    logic          fire_nxt;

    // Next-state: count ticks spent firing; fire while the quota remains.
    always_comb begin
        fired_nxt = fired_cnt + CW'(fire && ms_tick);
        fire_nxt  = trip && !zc_win && (32'(fired_nxt) < FIRE_TICKS);
    end

    // Register the fire output and the count of ticks spent firing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fired_cnt <= '0;
            fire      <= 1'b0;
        end else begin
            fired_cnt <= fired_nxt;
            fire      <= fire_nxt;
        end
    end
endmodule

// File: rtl/trip_timer.sv
// Module: inverse-time trip timer (top).
// Runs one tick timer per current band plus a saturation sample counter.
// Latches a trip request when any of them expires, and passes the request
// through the zero-crossing fire gate.
// Assumes: mag_ma is already filtered and in mA; ms_tick is a 1 ms pulse.
module trip_timer #(
    parameter int unsigned MAG_W       = 10,
    parameter int unsigned BAND0_MA    = 5,
    parameter int unsigned BAND1_MA    = 20,
    parameter int unsigned BAND2_MA    = 40,
    parameter int unsigned BAND0_TICKS = 120,
    parameter int unsigned BAND1_TICKS = 60,
    parameter int unsigned BAND2_TICKS = 20,
    parameter int unsigned SAT_MA      = 300,
    parameter int unsigned SAT_SAMPLES = 4,
    parameter int unsigned FIRE_TICKS  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample_vld,
    input  logic [MAG_W-1:0] mag_ma,
    input  logic             zc_win,
    input  logic             ms_tick,
    output logic             trip_req,
    output logic             scr_fire
);
    import tt_pkg::*;

    localparam int unsigned LO_TAB  [NUM_BANDS] = '{BAND0_MA, BAND1_MA, BAND2_MA};
    localparam int unsigned LIM_TAB [NUM_BANDS] = '{BAND0_TICKS, BAND1_TICKS, BAND2_TICKS};

    logic [NUM_BANDS-1:0] band_exp;
    logic                 sat_hit;
    logic                 any_hit;

    for (genvar gi = 0; gi < NUM_BANDS; gi++) begin : g_band
        tt_band_timer #(
            .MAG_W (MAG_W),
            .LO_MA (LO_TAB[gi]),
            .LIMIT (LIM_TAB[gi])
        ) u_band (
            .clk        (clk),
            .rst_n      (rst_n),
            .sample_vld (sample_vld),
            .mag_ma     (mag_ma),
            .ms_tick    (ms_tick),
            .expired    (band_exp[gi])
        );
    end

    tt_sat_detect #(
        .MAG_W       (MAG_W),
        .SAT_MA      (SAT_MA),
        .SAT_SAMPLES (SAT_SAMPLES)
    ) u_sat (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample_vld (sample_vld),
        .mag_ma     (mag_ma),
        .hit        (sat_hit)
    );

    assign any_hit = (|band_exp) || sat_hit;

    // Latch the trip request until reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trip_req <= 1'b0;
        end else if (any_hit) begin
            trip_req <= 1'b1;
        end
    end

    tt_fire_gate #(
        .FIRE_TICKS (FIRE_TICKS)
    ) u_fire (
        .clk     (clk),
        .rst_n   (rst_n),
        .trip    (trip_req),
        .zc_win  (zc_win),
        .ms_tick (ms_tick),
        .fire    (scr_fire)
    );
endmodule

// File: rtl/trip_timer_chk.sv
// Module: protocol checker for trip_timer, attached by bind.
// Observes the top-level ports only; keeps its own count of ticks spent firing.
module trip_timer_chk #(
    parameter int unsigned FIRE_TICKS = 3
) (
    input logic clk,
    input logic rst_n,
    input logic zc_win,
    input logic ms_tick,
    input logic trip_req,
    input logic scr_fire
);
    localparam int unsigned CW = $clog2(FIRE_TICKS + 2);

    logic [CW-1:0] seen_ticks;

    // Count the ticks observed while the fire output is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_ticks <= '0;
        end else if (scr_fire && ms_tick && (32'(seen_ticks) <= FIRE_TICKS)) begin
            seen_ticks <= seen_ticks + 1'b1;
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!trip_req && !scr_fire));                                   // R1
    AST_TRIP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        trip_req |=> trip_req);                                                 // R9
    AST_FIRE_NEEDS_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
        scr_fire |-> trip_req);                                                 // R10
    AST_FIRE_OUTSIDE_ZC: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scr_fire) |-> !$past(zc_win));                                    // R10
    AST_FIRE_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        32'(seen_ticks) <= FIRE_TICKS);                                         // R11
endmodule

bind trip_timer trip_timer_chk #(.FIRE_TICKS(FIRE_TICKS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .zc_win   (zc_win),
    .ms_tick  (ms_tick),
    .trip_req (trip_req),
    .scr_fire (scr_fire)
);

// File: tb/trip_timer_bench.sv
// Directed bench for trip_timer: one task per scenario, each checking itself.
module trip_timer_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sample_vld = 1'b0;
    logic [9:0] mag_ma = '0;
    logic       zc_win = 1'b0;
    logic       ms_tick = 1'b0;
    logic       trip_req;
    logic       scr_fire;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    trip_timer u_trip_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample_vld (sample_vld),
        .mag_ma     (mag_ma),
        .zc_win     (zc_win),
        .ms_tick    (ms_tick),
        .trip_req   (trip_req),
        .scr_fire   (scr_fire)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(posedge clk); #1;
        rst_n = 1'b0; sample_vld = 1'b0; ms_tick = 1'b0; zc_win = 1'b0;
        idle(3);
        rst_n = 1'b1;
        idle(1);
    endtask

    task automatic sample(input int m);
        sample_vld = 1'b1; mag_ma = 10'(m);
        idle(1);
        sample_vld = 1'b0;
        idle(2);
    endtask

    task automatic tick();
        ms_tick = 1'b1;
        idle(1);
        ms_tick = 1'b0;
        idle(2);
    endtask

    task automatic run(input int m, input int n);
        for (int i = 0; i < n; i++) begin
            sample(m);
            tick();
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        idle(3);
        @(negedge clk);
        chk("R1", "trip in reset", trip_req, 1'b0);
        chk("R1", "fire in reset", scr_fire, 1'b0);
        rst_n = 1'b1;
        @(posedge clk); @(negedge clk);
        chk("R1", "trip after release", trip_req, 1'b0);
        chk("R1", "fire after release", scr_fire, 1'b0);
    endtask

    task automatic t_band(input string req, input int m, input int lim);
        do_reset();
        run(m, lim - 1);
        @(negedge clk);
        chk(req, "one tick short", trip_req, 1'b0);
        run(m, 1);
        @(negedge clk);
        chk(req, "at limit", trip_req, 1'b1);
    endtask

    task automatic t_leak();
        do_reset();
        run(4, 300);
        @(negedge clk);
        chk("R2", "4 mA for 300 ticks", trip_req, 1'b0);
    endtask

    task automatic t_clear();
        do_reset();
        run(30, 50);
        run(3, 1);
        run(30, 59);
        @(negedge clk);
        chk("R7", "dip cleared mid timer", trip_req, 1'b0);
        run(30, 1);
        @(negedge clk);
        chk("R7", "fresh 60 ticks after dip", trip_req, 1'b1);
    endtask

    task automatic t_fall();
        do_reset();
        run(50, 15);
        run(10, 104);
        @(negedge clk);
        chk("R8", "119 ticks in low band total", trip_req, 1'b0);
        run(10, 1);
        @(negedge clk);
        chk("R8", "120 ticks in low band total", trip_req, 1'b1);
    endtask

    task automatic t_sat();
        do_reset();
        sample(350); sample(350); sample(350); sample(100); sample(350);
        @(negedge clk);
        chk("R6", "broken saturation run", trip_req, 1'b0);
        sample(350); sample(350);
        @(negedge clk);
        chk("R6", "three of four", trip_req, 1'b0);
        sample(400);
        @(negedge clk);
        chk("R6", "four consecutive", trip_req, 1'b1);
        run(0, 5);
        @(negedge clk);
        chk("R9", "latched after current gone", trip_req, 1'b1);
    endtask

    task automatic t_fire();
        do_reset();
        zc_win = 1'b1;
        sample(300); sample(300); sample(300); sample(300);
        @(negedge clk);
        chk("R10", "trip raised in window", trip_req, 1'b1);
        chk("R10", "no fire in window", scr_fire, 1'b0);
        for (int i = 0; i < 5; i++) tick();
        @(negedge clk);
        chk("R10", "no fire after window ticks", scr_fire, 1'b0);
        zc_win = 1'b0;
        idle(2);
        @(negedge clk);
        chk("R10", "fire once window closes", scr_fire, 1'b1);
        tick(); tick();
        @(negedge clk);
        chk("R11", "still firing after 2 ticks", scr_fire, 1'b1);
        zc_win = 1'b1;
        idle(2);
        @(negedge clk);
        chk("R10", "blanked in window", scr_fire, 1'b0);
        tick(); tick();
        zc_win = 1'b0;
        idle(2);
        @(negedge clk);
        chk("R11", "window ticks not counted", scr_fire, 1'b1);
        tick();
        idle(2);
        @(negedge clk);
        chk("R11", "stops after third tick", scr_fire, 1'b0);
        tick();
        @(negedge clk);
        chk("R11", "stays off", scr_fire, 1'b0);
        chk("R9", "trip still held", trip_req, 1'b1);
    endtask

    initial begin
        t_reset();
        t_leak();
        t_band("R3", 10, 120);
        t_band("R4", 30, 60);
        t_band("R5", 45, 20);
        t_clear();
        t_fall();
        t_sat();
        t_fire();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule